// File: doc/BRIEF.md
# Two-Level Translation Cache Controller

This block caches virtual-to-physical translations in two tiers. The inner tier has two small
fully associative caches, one for instruction fetches and one for data accesses. The outer
tier is one larger fully associative cache that both paths share. Every entry is tagged with
an address-space identifier. It also records the mapped size, which is a 4 KB page, a 2 MB
region or a 1 GB region. The tag compare ignores the offset bits of that size, so one entry
covers its whole region.

A requester presents a virtual address, an identifier and an instruction/data select. The
request is handled in a fixed order:
- If the inner cache of the selected path hits, the answer comes back in the same cycle.
- Otherwise the controller probes the shared cache one cycle later. A hit there answers and refills the inner cache of the requesting path.
- If both caches miss, the controller raises a request to an external table walker and waits for its completion. A successful walk fills the shared cache and the inner cache of the requesting path.
- A walker fault is returned to the requester and fills no entry.

A single input drops every entry of one identifier in all three caches within one cycle. A second input empties all three caches.

The controller has three states: `ST_IDLE` accepts lookups, `ST_MAIN` probes the shared cache, and `ST_WALK` waits for the walker. It makes these transitions:
- `ST_IDLE -> ST_MAIN` on an accepted lookup that misses its inner cache.
- `ST_MAIN -> ST_IDLE` on a shared hit.
- `ST_MAIN -> ST_WALK` on a shared miss.
- `ST_WALK -> ST_IDLE` when the walker reports completion.

In any other case the state holds.

Top module: `tlb_hier_ctrl`

## Requirements
- R1: After reset all three caches are empty, `lk_ready` is 1, and `rsp_valid` and `walk_req` are 0. The first lookup after reset therefore goes to the walker.
- R2: The instruction and data inner caches are separate. A translation that is filled only through the data path misses the instruction inner cache, so an instruction lookup for it is answered from the shared cache.
- R3: A lookup accepted in `ST_IDLE` that hits the inner cache of its path raises `rsp_valid` in the same cycle, with `rsp_src` = 0.
- R4: A hit requires an equal identifier. The same address under a different identifier misses every level.
- R5: An inner miss that hits the shared cache answers one cycle after acceptance, with `rsp_src` = 1. It also refills the inner cache of the requesting path, so a repeat of the lookup hits with `rsp_src` = 0.
- R6: A miss in both levels holds `walk_req` high, with `walk_va` and `walk_asid` equal to the request, until `walk_done`. The response is given in the `walk_done` cycle with `rsp_src` = 2. Its address is the walker base with the offset bits taken from the request.
- R7: A walk that completes without a fault fills the shared cache and the requesting inner cache. A walk that reports `walk_fault` answers with `rsp_fault` = 1 and fills nothing, so a repeat of the lookup walks again.
- R8: The size code is 0 = 4 KB, 1 = 2 MB and 2 = 1 GB. It keeps 12, 21 or 30 low address bits as offset. Any address inside a cached region hits, and the result is the base with those offset bits copied from the request.
- R9: `inv_en` removes every entry whose identifier equals `inv_asid` from all three caches in one cycle. Entries of other identifiers stay.
- R10: `flush_all` empties all three caches in one cycle.
- R11: While a miss is in service (`ST_MAIN` or `ST_WALK`), `lk_ready` is 0 and no lookup is accepted.
- R12: Each cache replaces entries in round-robin order. With 8 inner entries, the ninth fill on one path evicts the oldest fill of that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_is_instr | input | 1 | 1 = instruction path, 0 = data path |
| lk_va | input | VA_W | Virtual address |
| lk_asid | input | ASID_W | Address-space identifier |
| lk_ready | output | 1 | Lookup accepted when high |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | PA_W | Translated address |
| rsp_size | output | 2 | Size code of the translation |
| rsp_src | output | 2 | 0 inner, 1 shared, 2 walker |
| rsp_fault | output | 1 | Walker fault for this request |
| walk_req | output | 1 | Walk request, held until done |
| walk_va | output | VA_W | Address to walk |
| walk_asid | output | ASID_W | Identifier to walk |
| walk_done | input | 1 | Walk complete |
| walk_fault | input | 1 | Walk failed |
| walk_pa | input | PA_W | Walked base address |
| walk_size | input | 2 | Walked size code |
| inv_en | input | 1 | Invalidate by identifier |
| inv_asid | input | ASID_W | Identifier to invalidate |
| flush_all | input | 1 | Empty all caches |

## Verification
A stale or lost entry shows up at the ports as a change in `rsp_src` on the next lookup to that address. For example, a fill that was missed turns a later inner hit into a shared hit or a walk. This is visible within two cycles, or after the walker latency. A corrupted size code or base shows up as a wrong `rsp_pa` on the first lookup that lands in the region away from its base page. A stuck state shows up as `lk_ready` staying low and `walk_req` either not rising or not falling.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Size code of a translation: 4 KB page, 2 MB region, 1 GB region.
    localparam logic [1:0] SZ_4K = 2'd0;
    localparam logic [1:0] SZ_2M = 2'd1;
    localparam logic [1:0] SZ_1G = 2'd2;

    // Where a response came from.
    localparam logic [1:0] SRC_MICRO = 2'd0;
    localparam logic [1:0] SRC_MAIN  = 2'd1;
    localparam logic [1:0] SRC_WALK  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAIN = 2'd1,
        ST_WALK = 2'd2
    } miss_state_e;

    // Number of low address bits that form the offset for a size code.
    function automatic int unsigned off_bits(input logic [1:0] sz);
        unique case (sz)
            SZ_2M:   return 21;
            SZ_1G:   return 30;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 48,
    parameter int PA_W    = 48,
    parameter int ASID_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [1:0]        lk_size,
    input  logic              fill_en,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [1:0]        fill_size,
    input  logic              inv_en,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              flush
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [VA_W-1:0]    tag_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    logic [PA_W-1:0]    base_q [ENTRIES];
    logic [1:0]         size_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   sel;

    function automatic logic [VA_W-1:0] va_keep(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        m = '1;
        return m << off_bits(sz);
    endfunction

    function automatic logic [PA_W-1:0] pa_keep(input logic [1:0] sz);
        logic [PA_W-1:0] m;
        m = '1;
        return m << off_bits(sz);
    endfunction

    // Per-entry compare, offset bits of the entry's size ignored.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = valid_q[e] && (asid_q[e] == lk_asid) &&
                          (((tag_q[e] ^ lk_va) & va_keep(size_q[e])) == '0);
    end

    // Lowest matching index wins.
    always_comb begin
        lk_hit = 1'b0;
        sel    = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) begin
                lk_hit = 1'b1;
                sel    = IDX_W'(e);
            end
        end
        lk_size = size_q[sel];
        lk_pa   = (base_q[sel] & pa_keep(size_q[sel])) |
                  (PA_W'(lk_va) & ~pa_keep(size_q[sel]));
    end

    // Valid bits and replacement pointer: flush beats invalidate beats fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (inv_en) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (asid_q[e] == inv_asid) valid_q[e] <= 1'b0;
            end
        end else if (fill_en) begin
            valid_q[rr_q] <= 1'b1;
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // Payload needs no reset: guarded by valid_q.
    always_ff @(posedge clk) begin
        if (rst_n && !flush && !inv_en && fill_en) begin
            tag_q[rr_q]  <= fill_va;
            asid_q[rr_q] <= fill_asid;
            base_q[rr_q] <= fill_pa;
            size_q[rr_q] <= fill_size;
        end
    end

    // R10: a flush leaves no valid entry behind.
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0))
        else $error("flush left a valid entry");

    // R9: after an identifier invalidate no entry of that identifier survives.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_inv_chk
        p_inv_drops_asid_r9: assert property (@(posedge clk) disable iff (!rst_n)
            inv_en |=> !(valid_q[e] && (asid_q[e] == $past(inv_asid))))
            else $error("entry survived identifier invalidate");
    end

endmodule

// File: rtl/tlb_miss_fsm.sv
module tlb_miss_fsm
    import tlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lk_valid,
    input  logic       micro_hit,
    input  logic       main_hit,
    input  logic       walk_done,
    input  logic       walk_fault,
    output logic       lk_ready,
    output logic       cap_en,
    output logic       rsp_valid,
    output logic [1:0] rsp_src,
    output logic       walk_req,
    output logic       fill_micro,
    output logic       fill_main,
    output logic       in_main
);
    miss_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_valid && !micro_hit) state_d = ST_MAIN;
            ST_MAIN: state_d = main_hit ? ST_IDLE : ST_WALK;
            ST_WALK: if (walk_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        lk_ready   = 1'b0;
        cap_en     = 1'b0;
        rsp_valid  = 1'b0;
        rsp_src    = SRC_MICRO;
        walk_req   = 1'b0;
        fill_micro = 1'b0;
        fill_main  = 1'b0;
        in_main    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                lk_ready = 1'b1;
                if (lk_valid) begin
                    if (micro_hit) rsp_valid = 1'b1;
                    else           cap_en    = 1'b1;
                end
            end
            ST_MAIN: begin
                in_main = 1'b1;
                if (main_hit) begin
                    rsp_valid  = 1'b1;
                    rsp_src    = SRC_MAIN;
                    fill_micro = 1'b1;
                end
            end
            ST_WALK: begin
                walk_req = 1'b1;
                if (walk_done) begin
                    rsp_valid  = 1'b1;
                    rsp_src    = SRC_WALK;
                    fill_micro = !walk_fault;
                    fill_main  = !walk_fault;
                end
            end
            default: ;
        endcase
    end

    // R6: the walk request is held until the walker completes.
    p_walk_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_done |=> walk_req)
        else $error("walk request dropped early");

    // R11: an accepted inner miss blocks the next lookup.
    p_miss_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready && !rsp_valid |=> !lk_ready)
        else $error("lookup accepted during miss service");

    // R5: a shared-cache answer comes exactly one cycle after capture.
    p_main_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_src == SRC_MAIN) |-> $past(cap_en))
        else $error("shared answer not one cycle after capture");

endmodule

// File: rtl/tlb_hier_ctrl.sv
module tlb_hier_ctrl
    import tlb_pkg::*;
#(
    parameter int VA_W          = 48,
    parameter int PA_W          = 48,
    parameter int ASID_W        = 16,
    parameter int MICRO_ENTRIES = 8,
    parameter int MAIN_ENTRIES  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_is_instr,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_size,
    output logic [1:0]        rsp_src,
    output logic              rsp_fault,
    output logic              walk_req,
    output logic [VA_W-1:0]   walk_va,
    output logic [ASID_W-1:0] walk_asid,
    input  logic              walk_done,
    input  logic              walk_fault,
    input  logic [PA_W-1:0]   walk_pa,
    input  logic [1:0]        walk_size,
    input  logic              inv_en,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic              flush_all
);
    localparam int NPATH = 2;   // index 0 = data, 1 = instruction

    logic [VA_W-1:0]   req_va_q;
    logic [ASID_W-1:0] req_asid_q;
    logic              req_instr_q;

    logic [NPATH-1:0]  micro_hit;
    logic [PA_W-1:0]   micro_pa   [NPATH];
    logic [1:0]        micro_size [NPATH];
    logic [NPATH-1:0]  micro_fill;

    logic              main_hit;
    logic [PA_W-1:0]   main_pa;
    logic [1:0]        main_size;

    logic              cap_en, fill_micro, fill_main, in_main;
    logic              sel_micro_hit;
    logic [PA_W-1:0]   fill_pa;
    logic [1:0]        fill_size;
    logic [PA_W-1:0]   walk_xlat;
    logic [1:0]        fsm_src;
    logic              fsm_rsp;

    function automatic logic [PA_W-1:0] compose(input logic [PA_W-1:0] base,
                                                input logic [VA_W-1:0] va,
                                                input logic [1:0]      sz);
        logic [PA_W-1:0] m;
        m = '1;
        m = m << off_bits(sz);
        return (base & m) | (PA_W'(va) & ~m);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_va_q    <= '0;
            req_asid_q  <= '0;
            req_instr_q <= 1'b0;
        end else if (cap_en) begin
            req_va_q    <= lk_va;
            req_asid_q  <= lk_asid;
            req_instr_q <= lk_is_instr;
        end
    end

    assign sel_micro_hit = lk_is_instr ? micro_hit[1] : micro_hit[0];

    // Refill data: shared-cache result in ST_MAIN, walker result in ST_WALK.
    assign fill_pa   = in_main ? main_pa   : walk_pa;
    assign fill_size = in_main ? main_size : walk_size;

    for (genvar g = 0; g < NPATH; g++) begin : g_micro
        assign micro_fill[g] = fill_micro && (req_instr_q == (g == 1));
        tlb_array #(
            .ENTRIES(MICRO_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
        ) u_micro (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_va     (lk_va),
            .lk_asid   (lk_asid),
            .lk_hit    (micro_hit[g]),
            .lk_pa     (micro_pa[g]),
            .lk_size   (micro_size[g]),
            .fill_en   (micro_fill[g]),
            .fill_va   (req_va_q),
            .fill_asid (req_asid_q),
            .fill_pa   (fill_pa),
            .fill_size (fill_size),
            .inv_en    (inv_en),
            .inv_asid  (inv_asid),
            .flush     (flush_all)
        );
    end

    tlb_array #(
        .ENTRIES(MAIN_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
    ) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_va     (req_va_q),
        .lk_asid   (req_asid_q),
        .lk_hit    (main_hit),
        .lk_pa     (main_pa),
        .lk_size   (main_size),
        .fill_en   (fill_main),
        .fill_va   (req_va_q),
        .fill_asid (req_asid_q),
        .fill_pa   (walk_pa),
        .fill_size (walk_size),
        .inv_en    (inv_en),
        .inv_asid  (inv_asid),
        .flush     (flush_all)
    );

    tlb_miss_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .micro_hit  (sel_micro_hit),
        .main_hit   (main_hit),
        .walk_done  (walk_done),
        .walk_fault (walk_fault),
        .lk_ready   (lk_ready),
        .cap_en     (cap_en),
        .rsp_valid  (fsm_rsp),
        .rsp_src    (fsm_src),
        .walk_req   (walk_req),
        .fill_micro (fill_micro),
        .fill_main  (fill_main),
        .in_main    (in_main)
    );

    assign walk_xlat = compose(walk_pa, req_va_q, walk_size);
    assign walk_va   = req_va_q;
    assign walk_asid = req_asid_q;
    assign rsp_valid = fsm_rsp;
    assign rsp_src   = fsm_src;
    assign rsp_fault = fsm_rsp && (fsm_src == SRC_WALK) && walk_fault;

    always_comb begin
        unique case (fsm_src)
            SRC_MAIN: begin
                rsp_pa   = main_pa;
                rsp_size = main_size;
            end
            SRC_WALK: begin
                rsp_pa   = walk_xlat;
                rsp_size = walk_size;
            end
            default: begin
                rsp_pa   = lk_is_instr ? micro_pa[1]   : micro_pa[0];
                rsp_size = lk_is_instr ? micro_size[1] : micro_size[0];
            end
        endcase
    end

    // R6: the walked address and identifier stay put while the request is pending.
    p_walk_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_done |=> $stable(walk_va) && $stable(walk_asid))
        else $error("walk address changed while pending");

    // R7: a fault answer only comes from the walker.
    p_fault_from_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> walk_done)
        else $error("fault without walker completion");

endmodule

// File: tb/sim_tlb_hier_ctrl.sv
module sim_tlb_hier_ctrl;
    localparam int VA_W = 48, PA_W = 48, ASID_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0, lk_is_instr = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_ready, rsp_valid, rsp_fault, walk_req;
    logic [PA_W-1:0]   rsp_pa;
    logic [1:0]        rsp_size, rsp_src;
    logic [VA_W-1:0]   walk_va;
    logic [ASID_W-1:0] walk_asid;
    logic              walk_done = 1'b0, walk_fault = 1'b0;
    logic [PA_W-1:0]   walk_pa = '0;
    logic [1:0]        walk_size = '0;
    logic              inv_en = 1'b0, flush_all = 1'b0;
    logic [ASID_W-1:0] inv_asid = '0;

    int checks = 0, fails = 0;

    typedef struct packed {
        logic [1:0]      src;
        logic [PA_W-1:0] pa;
        logic [1:0]      sz;
        logic            flt;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    // walker model settings
    logic [PA_W-1:0]   wk_base;
    logic [1:0]        wk_sz;
    logic              wk_flt;
    logic [VA_W-1:0]   wk_va;
    logic [ASID_W-1:0] wk_asid;

    always #4 clk = ~clk;   // 125 MHz

    tlb_hier_ctrl u0 (.*);

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [PA_W-1:0] xlat(input logic [PA_W-1:0] base, input logic [VA_W-1:0] va,
                                             input logic [1:0] sz);
        logic [PA_W-1:0] m;
        m = (sz == 2'd1) ? 48'h1F_FFFF : (sz == 2'd2) ? 48'h3FFF_FFFF : 48'hFFF;
        return (base & ~m) | (va & m);
    endfunction

    task automatic arm(input logic [PA_W-1:0] base, input logic [1:0] sz, input bit flt,
                       input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid);
        wk_base = base; wk_sz = sz; wk_flt = flt; wk_va = va; wk_asid = asid;
    endtask

    // driver: issue one lookup and push the expected response
    task automatic lookup(input bit instr, input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid,
                          input logic [1:0] src, input logic [PA_W-1:0] pa, input logic [1:0] sz,
                          input bit flt, input string tag);
        @(posedge clk); #1;
        lk_valid = 1'b1; lk_is_instr = instr; lk_va = va; lk_asid = asid;
        exp_q.push_back('{src: src, pa: pa, sz: sz, flt: flt});
        tag_q.push_back(tag);
        @(posedge clk); #1;
        lk_valid = 1'b0;
        if (src != 2'd0) begin
            @(negedge clk);
            chk(lk_ready == 1'b0, "R11 ready during miss service", 64'(lk_ready), 64'd0);
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "unexpected response", 64'(rsp_src), 64'd3);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rsp_src == e.src, {t, " src"}, 64'(rsp_src), 64'(e.src));
                    chk(rsp_fault == e.flt, {t, " fault"}, 64'(rsp_fault), 64'(e.flt));
                    if (!e.flt) begin
                        chk(rsp_pa == e.pa, {t, " pa"}, 64'(rsp_pa), 64'(e.pa));
                        chk(rsp_size == e.sz, {t, " size"}, 64'(rsp_size), 64'(e.sz));
                    end
                end
            end
        end
    end

    // walker model
    initial begin
        forever begin
            @(negedge clk);
            if (walk_req) begin
                chk(walk_va == wk_va, "R6 walk_va", 64'(walk_va), 64'(wk_va));
                chk(walk_asid == wk_asid, "R6 walk_asid", 64'(walk_asid), 64'(wk_asid));
                repeat (2) @(posedge clk);
                #1;
                chk(walk_req == 1'b1, "R6 walk_req held", 64'(walk_req), 64'd1);
                walk_done = 1'b1; walk_fault = wk_flt; walk_pa = wk_base; walk_size = wk_sz;
                @(posedge clk); #1;
                walk_done = 1'b0; walk_fault = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [ASID_W-1:0] A = 16'h0011, B = 16'h0022;
    localparam logic [VA_W-1:0] V1 = 48'h0000_1234_5678;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(lk_ready == 1'b1, "R1 ready after reset", 64'(lk_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        chk(walk_req == 1'b0, "R1 no walk after reset", 64'(walk_req), 64'd0);

        // R1/R6: empty after reset, first lookup walks
        arm(48'h0000_0ABC_D000, 2'd0, 1'b0, V1, A);
        lookup(1'b0, V1, A, 2'd2, 48'h0000_0ABC_D678, 2'd0, 1'b0, "R6 first walk");
        // R3/R7: now hits the data inner cache
        lookup(1'b0, V1, A, 2'd0, 48'h0000_0ABC_D678, 2'd0, 1'b0, "R3 inner hit");
        // R2/R5: instruction path misses inner, hits shared
        lookup(1'b1, V1, A, 2'd1, 48'h0000_0ABC_D678, 2'd0, 1'b0, "R2 split paths");
        lookup(1'b1, V1, A, 2'd0, 48'h0000_0ABC_D678, 2'd0, 1'b0, "R5 refill after shared hit");
        // R4: different identifier misses everywhere
        arm(48'h0000_0555_5000, 2'd0, 1'b0, V1, B);
        lookup(1'b0, V1, B, 2'd2, 48'h0000_0555_5678, 2'd0, 1'b0, "R4 identifier mismatch");
        // R8: 2 MB region
        arm(48'h0000_8000_0000, 2'd1, 1'b0, 48'h0000_4021_2345, A);
        lookup(1'b0, 48'h0000_4021_2345, A, 2'd2, 48'h0000_8001_2345, 2'd1, 1'b0, "R8 2MB walk");
        lookup(1'b0, 48'h0000_403F_FF00, A, 2'd0, 48'h0000_801F_FF00, 2'd1, 1'b0, "R8 2MB region hit");
        // R8: 1 GB region on the instruction path
        arm(48'h0003_C000_0000, 2'd2, 1'b0, 48'h0012_4567_89AB, A);
        lookup(1'b1, 48'h0012_4567_89AB, A, 2'd2, 48'h0003_C567_89AB, 2'd2, 1'b0, "R8 1GB walk");
        lookup(1'b1, 48'h0012_7000_0010, A, 2'd0, 48'h0003_F000_0010, 2'd2, 1'b0, "R8 1GB region hit");
        // R7: fault fills nothing
        arm(48'h0, 2'd0, 1'b1, 48'h0000_7777_7000, A);
        lookup(1'b0, 48'h0000_7777_7000, A, 2'd2, 48'h0, 2'd0, 1'b1, "R7 fault");
        lookup(1'b0, 48'h0000_7777_7000, A, 2'd2, 48'h0, 2'd0, 1'b1, "R7 fault repeats walk");

        // R9: invalidate identifier B
        @(posedge clk); #1 inv_en = 1'b1; inv_asid = B;
        @(posedge clk); #1 inv_en = 1'b0;
        arm(48'h0000_0555_5000, 2'd0, 1'b0, V1, B);
        lookup(1'b0, V1, B, 2'd2, 48'h0000_0555_5678, 2'd0, 1'b0, "R9 invalidated identifier walks");
        lookup(1'b0, V1, A, 2'd0, 48'h0000_0ABC_D678, 2'd0, 1'b0, "R9 other identifier kept");

        // R10: flush everything
        @(posedge clk); #1 flush_all = 1'b1;
        @(posedge clk); #1 flush_all = 1'b0;
        arm(48'h0003_C000_0000, 2'd2, 1'b0, 48'h0012_4567_89AB, A);
        lookup(1'b1, 48'h0012_4567_89AB, A, 2'd2, 48'h0003_C567_89AB, 2'd2, 1'b0, "R10 flush instr");
        arm(48'h0000_0ABC_D000, 2'd0, 1'b0, V1, A);
        lookup(1'b0, V1, A, 2'd2, 48'h0000_0ABC_D678, 2'd0, 1'b0, "R10 flush data");

        // R12: eight more data fills evict the oldest (V1)
        for (int k = 0; k < 8; k++) begin
            logic [VA_W-1:0] va;
            logic [PA_W-1:0] pb;
            va = 48'h0000_2000_0010 + (48'(k) << 12);
            pb = 48'h0000_6000_0000 + (48'(k) << 12);
            arm(pb, 2'd0, 1'b0, va, A);
            lookup(1'b0, va, A, 2'd2, xlat(pb, va, 2'd0), 2'd0, 1'b0, "R12 fill");
        end
        lookup(1'b0, 48'h0000_2000_7010, A, 2'd0, 48'h0000_6000_7010, 2'd0, 1'b0, "R12 newest kept");
        lookup(1'b0, V1, A, 2'd1, 48'h0000_0ABC_D678, 2'd0, 1'b0, "R12 oldest evicted");
        lookup(1'b0, 48'h0000_2000_0010, A, 2'd1, 48'h0000_6000_0010, 2'd0, 1'b0, "R12 next evicted");

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule